// File: doc/BRIEF.md
# Programmable Frame Word Detector

This block sits behind a bit demodulator and searches its output stream for a start-of-frame marker. Every new bit arrives with a strobe and a quality flag that says whether the bit carried enough signal energy. The detector keeps the twelve most recent bits and their quality flags. It compares the bits with a programmable 12-bit frame word and accepts the window when two counts both reach their thresholds: the number of bits that agree with the pattern, and the number of bits flagged as good quality.

Once a window is accepted the detector raises its match flag and locks. Every bit that arrives after that is passed to a downstream bit/strobe pair, and no further frame search takes place. A clear input, or dropping the enable, returns it to searching with an empty window. While it is disabled both outputs stay low. All logic runs on one system clock. The input strobe is a level signal sampled by that clock, and each of its rising edges marks one new bit.

Top module: `fwd_frame_detector`

## Requirements
- R1: A synchronous active-high `rst` sets `match_o`, `out_bit_o` and `out_strobe_o` to 0 and empties the window.
- R2: The window holds the 12 most recent bits, received first to last. The first bit is compared with `pattern_i[11]` and the last with `pattern_i[0]`. The window is accepted when the count of bits equal to the pattern is at least `match_thr_i` and the count of bits with quality 1 is at least `qual_thr_i`.
- R3: No window is accepted until 12 bits have been taken in since the last reset, clear or disable.
- R4: A new bit is taken in when the clock samples `strobe_i` at 1 after sampling it at 0. On the clock edge that takes in the bit completing an accepted window, `match_o` goes from 0 to 1.
- R5: While matched, each later input strobe is forwarded. `out_strobe_o` rises one clock after `strobe_i` rises and falls one clock after it falls. The bit that completed the frame is not forwarded, and `out_strobe_o` is never 1 while `match_o` is 0.
- R6: `out_bit_o` changes only on the clock edge where `out_strobe_o` falls. At that edge it takes the bit sampled at the rise of that strobe. A clear or a disable also sets it to 0.
- R7: While matched, further frames are ignored and `match_o` stays 1 until a clear or a disable.
- R8: With `clr_i` at 1, the next clock sets `match_o`, `out_strobe_o` and `out_bit_o` to 0 and empties the window.
- R9: With `en_i` at 0, the detector takes no bits, empties its window, and holds `match_o`, `out_bit_o` and `out_strobe_o` at 0 from the next clock on.
- R10: A threshold above 12 can never be met, so with either threshold at 13 to 15 no window is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Detector enable |
| clr_i | input | 1 | Return to searching and empty the window |
| bit_i | input | 1 | Estimated data bit |
| qual_i | input | 1 | Quality flag of the bit, 1 = good energy |
| strobe_i | input | 1 | Bit strobe; each rising edge marks one bit |
| pattern_i | input | 12 | Frame word; bit 11 is compared with the oldest bit |
| match_thr_i | input | 4 | Minimum number of bits that must equal the pattern |
| qual_thr_i | input | 4 | Minimum number of bits with quality 1 |
| match_o | output | 1 | Frame accepted, detector locked |
| out_bit_o | output | 1 | Forwarded bit |
| out_strobe_o | output | 1 | Forwarded strobe |

## Verification
The bench first sends the frame word as only eleven bits. A detector that evaluates a partly filled window would accept there too early. It then runs windows that sit exactly at each threshold and one count below it. An off-by-one comparison would accept the short window or reject the exact one. After the lock the bench sends the frame word again and checks which bits come out. A design that keeps searching would re-trigger on it, and one that forwards the completing bit would shift the output stream by one. Thresholds of 13, enable drops during a forwarded strobe, and clears show whether the detector can accept an impossible window, leaks a strobe while disabled, or leaves stale window contents behind.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int FRAME_W = 12;
    localparam int THR_W   = 4;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } fwd_state_e;

    typedef struct packed {
        logic data;
        logic stb;
    } fwd_pair_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } fwd_edge_t;

endpackage

// File: rtl/fwd_window.sv
module fwd_window #(
    parameter int W  = fwd_pkg::FRAME_W,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         shift,
    input  logic         bit_i,
    input  logic         qual_i,
    output logic [W-1:0] nxt_bits,
    output logic [W-1:0] nxt_qual,
    output logic         nxt_full
);
    logic [W-1:0]  bits_q;
    logic [W-1:0]  qual_q;
    logic [CW-1:0] fill_q;

    // newest bit enters at the LSB, oldest sits at the MSB
    assign nxt_bits = {bits_q[W-2:0], bit_i};
    assign nxt_qual = {qual_q[W-2:0], qual_i};
    assign nxt_full = (fill_q >= CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            bits_q <= '0;
            qual_q <= '0;
            fill_q <= '0;
        end else if (shift) begin
            bits_q <= nxt_bits;
            qual_q <= nxt_qual;
            if (fill_q != CW'(W))
                fill_q <= fill_q + 1'b1;
        end
    end
endmodule

// File: rtl/fwd_accept.sv
module fwd_accept #(
    parameter int W  = fwd_pkg::FRAME_W,
    parameter int TW = fwd_pkg::THR_W,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  win_bits,
    input  logic [W-1:0]  win_qual,
    input  logic [W-1:0]  pattern,
    input  logic [TW-1:0] match_thr,
    input  logic [TW-1:0] qual_thr,
    output logic          accept
);
    logic [W-1:0]  agree;
    logic [CW-1:0] agree_cnt;
    logic [CW-1:0] good_cnt;

    assign agree = ~(win_bits ^ pattern);

    always_comb begin
        agree_cnt = '0;
        good_cnt  = '0;
        for (int i = 0; i < W; i++) begin
            agree_cnt = agree_cnt + CW'(agree[i]);
            good_cnt  = good_cnt + CW'(win_qual[i]);
        end
    end

    assign accept = (int'(agree_cnt) >= int'(match_thr)) &&
                    (int'(good_cnt) >= int'(qual_thr));
endmodule

// File: rtl/fwd_forward.sv
module fwd_forward
    import fwd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      locked,
    input  fwd_edge_t edge_i,
    input  logic      bit_i,
    output fwd_pair_t out_o
);
    logic held_q;
    logic stb_q;
    logic data_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            held_q <= 1'b0;
            stb_q  <= 1'b0;
            data_q <= 1'b0;
        end else begin
            if (edge_i.rise && locked) begin
                held_q <= bit_i;
                stb_q  <= 1'b1;
            end
            if (edge_i.fall && stb_q) begin
                stb_q  <= 1'b0;
                data_q <= held_q;
            end
        end
    end

    assign out_o = '{data: data_q, stb: stb_q};
endmodule

// File: rtl/fwd_frame_detector.sv
module fwd_frame_detector
    import fwd_pkg::*;
#(
    parameter int W  = FRAME_W,
    parameter int TW = THR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          clr_i,
    input  logic          bit_i,
    input  logic          qual_i,
    input  logic          strobe_i,
    input  logic [W-1:0]  pattern_i,
    input  logic [TW-1:0] match_thr_i,
    input  logic [TW-1:0] qual_thr_i,
    output logic          match_o,
    output logic          out_bit_o,
    output logic          out_strobe_o
);
    fwd_state_e   state_q;
    logic         stb_prev_q;
    fwd_edge_t    edg;
    logic         flush;
    logic         shift;
    logic [W-1:0] nxt_bits;
    logic [W-1:0] nxt_qual;
    logic         nxt_full;
    logic         accept;
    fwd_pair_t    fwd;

    assign edg   = '{rise: strobe_i & ~stb_prev_q, fall: ~strobe_i & stb_prev_q};
    assign flush = clr_i | ~en_i;
    assign shift = edg.rise && (state_q == ST_HUNT) && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_prev_q <= 1'b0;
            state_q    <= ST_HUNT;
        end else begin
            stb_prev_q <= strobe_i;
            if (flush)
                state_q <= ST_HUNT;
            else if (shift && nxt_full && accept)
                state_q <= ST_LOCK;
        end
    end

    fwd_window #(.W(W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .shift    (shift),
        .bit_i    (bit_i),
        .qual_i   (qual_i),
        .nxt_bits (nxt_bits),
        .nxt_qual (nxt_qual),
        .nxt_full (nxt_full)
    );

    fwd_accept #(.W(W), .TW(TW)) u_accept (
        .win_bits  (nxt_bits),
        .win_qual  (nxt_qual),
        .pattern   (pattern_i),
        .match_thr (match_thr_i),
        .qual_thr  (qual_thr_i),
        .accept    (accept)
    );

    fwd_forward u_forward (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .locked (state_q == ST_LOCK),
        .edge_i (edg),
        .bit_i  (bit_i),
        .out_o  (fwd)
    );

    assign match_o      = (state_q == ST_LOCK);
    assign out_bit_o    = fwd.data;
    assign out_strobe_o = fwd.stb;
endmodule

// File: rtl/fwd_frame_detector_chk.sv
module fwd_frame_detector_chk (
    input logic clk,
    input logic rst,
    input logic en_i,
    input logic clr_i,
    input logic strobe_i,
    input logic match_o,
    input logic out_bit_o,
    input logic out_strobe_o
);
    // R9: disable forces every output low on the next clock
    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!match_o && !out_strobe_o && !out_bit_o));

    // R8: clear drops the lock on the next clock
    p_clear_unlocks_r8: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !match_o);

    // R7: the lock holds while neither clear nor disable is present
    p_lock_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (match_o && en_i && !clr_i) |=> match_o);

    // R5: no forwarded strobe without a lock
    p_strobe_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
        out_strobe_o |-> match_o);

    // R6: the output bit only moves when the forwarded strobe ends
    p_bit_moves_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (en_i && !clr_i && !(out_strobe_o && !strobe_i)) |=> $stable(out_bit_o));

    // R4: a lock starts only on an edge that took in a bit
    p_lock_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(match_o) |-> ($past(strobe_i) && !out_strobe_o));
endmodule

bind fwd_frame_detector fwd_frame_detector_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .clr_i        (clr_i),
    .strobe_i     (strobe_i),
    .match_o      (match_o),
    .out_bit_o    (out_bit_o),
    .out_strobe_o (out_strobe_o)
);

// File: tb/fwd_frame_detector_tb.sv
module fwd_frame_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        qual_i = 1'b0;
    logic        strobe_i = 1'b0;
    logic [11:0] pattern_i = 12'hA5C;
    logic [3:0]  match_thr_i = 4'd12;
    logic [3:0]  qual_thr_i = 4'd12;
    logic        match_o, out_bit_o, out_strobe_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fwd_frame_detector dut_i (
        .clk(clk), .rst(rst), .en_i(en_i), .clr_i(clr_i),
        .bit_i(bit_i), .qual_i(qual_i), .strobe_i(strobe_i),
        .pattern_i(pattern_i), .match_thr_i(match_thr_i), .qual_thr_i(qual_thr_i),
        .match_o(match_o), .out_bit_o(out_bit_o), .out_strobe_o(out_strobe_o)
    );

    // behavioural reference
    logic [1:0] hist[$];
    logic m_lock = 0, m_ostb = 0, m_obit = 0, m_held = 0, m_prev = 0;

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_lock = 0; m_ostb = 0; m_obit = 0; m_held = 0; m_prev = 0;
        end else begin
            if (clr_i || !en_i) begin
                hist.delete();
                m_lock = 0; m_ostb = 0; m_obit = 0; m_held = 0;
            end else if (strobe_i && !m_prev) begin
                if (m_lock) begin
                    m_held = bit_i;
                    m_ostb = 1;
                end else begin
                    int mc, qc;
                    hist.push_back({bit_i, qual_i});
                    if (hist.size() > 12) void'(hist.pop_front());
                    if (hist.size() == 12) begin
                        mc = 0; qc = 0;
                        for (int i = 0; i < 12; i++) begin
                            if (hist[i][1] == pattern_i[11-i]) mc++;
                            if (hist[i][0]) qc++;
                        end
                        if (mc >= int'(match_thr_i) && qc >= int'(qual_thr_i)) m_lock = 1;
                    end
                end
            end else if (!strobe_i && m_prev && m_ostb) begin
                m_ostb = 0;
                m_obit = m_held;
            end
            m_prev = strobe_i;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        check("R4 match_o per-cycle", match_o, m_lock);
        check("R5 out_strobe_o per-cycle", out_strobe_o, m_ostb);
        check("R6 out_bit_o per-cycle", out_bit_o, m_obit);
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic send_bit(input logic b, input logic q);
        bit_i = b; qual_i = q; strobe_i = 1'b1;
        repeat (2) @(negedge clk);
        strobe_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // sends n bits of the word, oldest (bit 11) first; bad marks low-quality bits
    task automatic send_word(input logic [11:0] w, input logic [11:0] bad, input int n);
        for (int i = 11; i > 11 - n; i--) send_bit(w[i], !bad[i]);
    endtask

    task automatic pulse_clear();
        clr_i = 1'b1; @(negedge clk); clr_i = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 match after reset", match_o, 1'b0);
        check("R1 out_strobe after reset", out_strobe_o, 1'b0);
        check("R1 out_bit after reset", out_bit_o, 1'b0);
        rst = 1'b0; en_i = 1'b1;
        @(negedge clk);

        // R3: eleven bits are not enough, even if all agree
        send_word(12'hA5C, 12'h000, 11);
        check("R3 no accept on 11 bits", match_o, 1'b0);
        send_bit(1'b0, 1'b1);
        check("R2 full-agreement accept", match_o, 1'b1);

        // R5/R6: forwarded bits
        send_bit(1'b1, 1'b1);
        check("R6 forwarded bit 1", out_bit_o, 1'b1);
        send_bit(1'b0, 1'b0);
        check("R6 forwarded bit 0", out_bit_o, 1'b0);
        bit_i = 1'b1; strobe_i = 1'b1; @(negedge clk); @(negedge clk);
        check("R5 forwarded strobe high", out_strobe_o, 1'b1);
        strobe_i = 1'b0; @(negedge clk); @(negedge clk);
        check("R5 forwarded strobe low", out_strobe_o, 1'b0);

        // R7: frame word again while locked
        send_word(12'hA5C, 12'h000, 12);
        check("R7 lock kept", match_o, 1'b1);
        check("R7 last pattern bit forwarded", out_bit_o, 1'b0);

        // R8: clear
        pulse_clear();
        check("R8 clear drops match", match_o, 1'b0);
        check("R8 clear zeroes out_bit", out_bit_o, 1'b0);

        // R2 threshold boundary on agreement: one bit flipped
        send_word(12'hA5C ^ 12'h040, 12'h000, 12);
        check("R2 11 agree vs thr 12 rejects", match_o, 1'b0);
        pulse_clear();
        match_thr_i = 4'd11;
        send_word(12'hA5C ^ 12'h040, 12'h000, 12);
        check("R2 11 agree vs thr 11 accepts", match_o, 1'b1);
        pulse_clear();

        // R2 quality boundary
        match_thr_i = 4'd12; qual_thr_i = 4'd10;
        send_word(12'hA5C, 12'h111, 12);
        check("R2 9 good vs thr 10 rejects", match_o, 1'b0);
        pulse_clear();
        send_word(12'hA5C, 12'h011, 12);
        check("R2 10 good vs thr 10 accepts", match_o, 1'b1);
        pulse_clear();

        // R2 sliding window: pattern after junk bits
        send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1);
        send_word(12'h3C7, 12'h000, 12);
        check("R2 sliding window wrong pattern", match_o, 1'b0);
        pattern_i = 12'h3C7;
        send_word(12'h3C7, 12'h000, 12);
        check("R2 sliding window accepts", match_o, 1'b1);

        // R9: disable during forwarded strobe
        bit_i = 1'b1; strobe_i = 1'b1; @(negedge clk); @(negedge clk);
        en_i = 1'b0; @(negedge clk);
        check("R9 disable drops strobe", out_strobe_o, 1'b0);
        check("R9 disable drops match", match_o, 1'b0);
        strobe_i = 1'b0; @(negedge clk);
        send_word(12'h3C7, 12'h000, 12);
        check("R9 disabled ignores frame", match_o, 1'b0);
        check("R9 disabled out_bit low", out_bit_o, 1'b0);
        en_i = 1'b1; @(negedge clk);

        // R10: impossible thresholds
        qual_thr_i = 4'd0; match_thr_i = 4'd13;
        send_word(12'h3C7, 12'h000, 12);
        check("R10 match thr 13 never accepts", match_o, 1'b0);
        match_thr_i = 4'd0; qual_thr_i = 4'd15;
        send_word(12'h3C7, 12'h000, 12);
        check("R10 quality thr 15 never accepts", match_o, 1'b0);
        qual_thr_i = 4'd0;
        send_bit(1'b0, 1'b0);
        check("R2 zero thresholds accept full window", match_o, 1'b1);

        // R1: reset while locked
        rst = 1'b1; @(negedge clk);
        check("R1 reset drops match", match_o, 1'b0);
        rst = 1'b0; @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule